// File: doc/BRIEF.md
# Dual-Clock Serial Word Bridge

This block joins two framed serial ports, A and B, whose bit clocks are unrelated. Each port has its own frame marker, serial input and serial output. Traffic flows both ways at the same time. In each frame the block takes one word from a port, moves it safely into the other port's clock domain, and sends it on that port at its next frame marker.

The two clocks are free to drift, so the two frame rates never match exactly. The block absorbs the difference a whole word at a time. A word that is overtaken by a newer one is never sent. A reader that finds nothing new sends its last word again. A word is never sent torn or mixed.

Each direction has a capture shifter, a two-entry holding store and a send shifter. Only two single-bit controls cross the clock boundary, each through two flip-flops: a publish toggle going forward and a read-guard level going back.

Top module: `pcm_word_bridge`

## Requirements
- R1: A frame starts at the rising clock edge where the port's frame marker is first seen high after being low. The serial input sampled at that edge is the word's most significant bit. The next 15 rising edges give the remaining bits in falling significance. Later bits of the frame are ignored.
- R2: After the sixteenth bit, the writer stores the complete word in one of two holding entries. Successive writes alternate between the entries.
- R3: Every stored word flips a publish toggle that reaches the reader through two flip-flops. At its frame marker the reader takes a new word only if the synchronised toggle differs from the value it saw last. Otherwise any newer word that was overtaken is lost.
- R4: When no new toggle has arrived since the reader's last frame, the reader sends its previous word again.
- R5: The reader raises a read-guard flag at the frame-marker edge and loads its send register one clock later. The flag stays up for 3 clocks. The flag reaches the writer through two flip-flops, and a word that completes while the synchronised flag is high is discarded.
- R6: Output bits change on falling clock edges, most significant bit first. If the frame marker is detected at rising edge E, then the rising edges E+2 through E+17 observe bits 15 down to 0.
- R7: The serial output is 0 outside that 16-edge window. It carries an all-zero word until the first real word has been taken.
- R8: Every word sent is identical to a word that was fully captured on the other port before the sending frame began. Sent words never go back to an older word.
- R9: The A-to-B and B-to-A paths work at the same time and do not depend on each other.
- R10: Each port has a synchronous active-high reset in its own domain. While a port's reset is high, its serial output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Bit clock of port A |
| rst_a | input | 1 | Synchronous active-high reset, port A domain |
| fsync_a | input | 1 | Frame marker of port A |
| sdi_a | input | 1 | Serial data into port A |
| sdo_a | output | 1 | Serial data out of port A (carries words from port B) |
| clk_b | input | 1 | Bit clock of port B |
| rst_b | input | 1 | Synchronous active-high reset, port B domain |
| fsync_b | input | 1 | Frame marker of port B |
| sdi_b | input | 1 | Serial data into port B |
| sdo_b | output | 1 | Serial data out of port B (carries words from port A) |

## Verification
An input word is complete at the fifteenth rising edge after its frame edge. It is stored one edge later and becomes visible to the reader two reader clocks after that. Because of this lag, the bench does not predict which word a frame will carry. Instead, each word decoded at the output must be found among the input words that had finished before that output frame's marker edge, and the matched positions must never go backwards. The output is decoded only on rising edges E+2 to E+17 after the sink port's marker edge E, which is half a clock after each bit was driven, and it is compared with 0 on every other rising edge. A 10 ns against 10.3 ns half-period pair makes the A side produce more words than B can send, which forces both drops and repeats within the run.

// File: rtl/pcm_bridge_pkg.sv
`timescale 1ns/1ps
package pcm_bridge_pkg;
  // Default geometry shared by every lane of the bridge.
  localparam int unsigned PCM_WORD_W   = 16;  // bits per frame word (power of two)
  localparam int unsigned PCM_GUARD_LEN = 3;  // reader guard length in reader clocks
  localparam int unsigned PCM_PORTS    = 2;   // A and B
endpackage

// File: rtl/pcm_rx.sv
`timescale 1ns/1ps
// Capture shifter: assembles one word per frame in the source clock domain.
module pcm_rx #(
  parameter int unsigned WORD_W = pcm_bridge_pkg::PCM_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              sdi,
  output logic              done,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic             fs_q;
  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             start;

  assign start = fsync & ~fs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q <= 1'b0;
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
      word <= '0;
    end else begin
      fs_q <= fsync;
      done <= 1'b0;
      if (start) begin
        word <= {word[WORD_W-2:0], sdi};
        cnt  <= CNT_W'(1);
        busy <= 1'b1;
      end else if (busy) begin
        word <= {word[WORD_W-2:0], sdi};
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R1: a detected frame edge arms capture with one bit taken
  p_frame_arms_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && cnt == CNT_W'(1)));

  // R2: completion is a single-cycle strobe
  p_done_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/pcm_xfer.sv
`timescale 1ns/1ps
// Two-entry holding store between writer and reader clock domains.
module pcm_xfer #(
  parameter int unsigned WORD_W = pcm_bridge_pkg::PCM_WORD_W
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wr_done,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              rd_guard,
  input  logic              rd_sel,
  output logic              rd_tog,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] hold [2];
  logic              wsel;
  logic              tog;
  logic [1:0]        guard_sync;
  logic [1:0]        tog_sync;
  logic              accept;

  assign accept = wr_done & ~guard_sync[1];

  // writer domain
  always_ff @(posedge wclk) begin
    if (wrst) begin
      guard_sync <= '0;
      wsel       <= 1'b0;
      tog        <= 1'b0;
      hold[0]    <= '0;
      hold[1]    <= '0;
    end else begin
      guard_sync <= {guard_sync[0], rd_guard};
      if (accept) begin
        hold[wsel] <= wr_word;
        wsel       <= ~wsel;
        tog        <= ~tog;
      end
    end
  end

  // reader domain
  always_ff @(posedge rclk) begin
    if (rrst) tog_sync <= '0;
    else      tog_sync <= {tog_sync[0], tog};
  end

  assign rd_tog  = tog_sync[1];
  assign rd_word = hold[rd_sel];

  // R3: the publish toggle moves only after a completed, unguarded word
  p_toggle_cause_r3: assert property (@(posedge wclk) disable iff (wrst)
    (tog != $past(tog)) |-> $past(wr_done && !guard_sync[1]));

  // R5: no holding entry changes while the synchronised guard is up
  p_guard_hold0_r5: assert property (@(posedge wclk) disable iff (wrst)
    (hold[0] != $past(hold[0])) |-> !$past(guard_sync[1]));
  p_guard_hold1_r5: assert property (@(posedge wclk) disable iff (wrst)
    (hold[1] != $past(hold[1])) |-> !$past(guard_sync[1]));
endmodule

// File: rtl/pcm_tx.sv
`timescale 1ns/1ps
// Send side: picks a fresh or repeated word at each frame and serialises it.
module pcm_tx #(
  parameter int unsigned WORD_W    = pcm_bridge_pkg::PCM_WORD_W,
  parameter int unsigned GUARD_LEN = pcm_bridge_pkg::PCM_GUARD_LEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              rd_tog,
  input  logic [WORD_W-1:0] rd_word,
  output logic              rd_sel,
  output logic              guard,
  output logic              sdo
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam int unsigned GC_W  = $clog2(GUARD_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              fs_q;
  logic              seen;
  logic              fresh;
  logic              pend;
  logic              act;
  logic [CNT_W-1:0]  bi;
  logic [WORD_W-1:0] word_q;
  logic [GC_W-1:0]   gcnt;
  logic              start;

  assign start = fsync & ~fs_q;
  assign guard = (gcnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q   <= 1'b0;
      seen   <= 1'b0;
      fresh  <= 1'b0;
      pend   <= 1'b0;
      act    <= 1'b0;
      bi     <= '0;
      word_q <= '0;
      gcnt   <= '0;
      rd_sel <= 1'b0;
    end else begin
      fs_q <= fsync;
      pend <= start;
      if (start)             gcnt <= GC_W'(GUARD_LEN);
      else if (gcnt != '0)   gcnt <= gcnt - 1'b1;
      if (start) begin
        fresh <= (rd_tog != seen);
        if (rd_tog != seen) begin
          seen   <= rd_tog;
          rd_sel <= ~rd_tog;
        end
      end
      if (pend) begin
        if (fresh) word_q <= rd_word;
        act <= 1'b1;
        bi  <= '0;
      end else if (act) begin
        if (bi == LAST) act <= 1'b0;
        else            bi  <= bi + 1'b1;
      end
    end
  end

  always_ff @(negedge clk) begin
    if (rst)      sdo <= 1'b0;
    else if (act) sdo <= word_q[LAST - bi];
    else          sdo <= 1'b0;
  end

  // R5: serialising begins only while the guard flag is up
  p_load_guarded_r5: assert property (@(posedge clk) disable iff (rst)
    (act && !$past(act)) |-> guard);

  // R4: a frame without a new toggle keeps the previous word
  p_repeat_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    (pend && !fresh) |=> $stable(word_q));
endmodule

// File: rtl/pcm_word_bridge.sv
`timescale 1ns/1ps
// Top: two independent lanes, A->B and B->A.
module pcm_word_bridge #(
  parameter int unsigned WORD_W    = pcm_bridge_pkg::PCM_WORD_W,
  parameter int unsigned GUARD_LEN = pcm_bridge_pkg::PCM_GUARD_LEN
) (
  input  logic clk_a,
  input  logic rst_a,
  input  logic fsync_a,
  input  logic sdi_a,
  output logic sdo_a,
  input  logic clk_b,
  input  logic rst_b,
  input  logic fsync_b,
  input  logic sdi_b,
  output logic sdo_b
);
  localparam int unsigned NP = pcm_bridge_pkg::PCM_PORTS;

  logic [NP-1:0] clk_v, rst_v, fs_v, sdi_v;

  assign clk_v = {clk_b, clk_a};
  assign rst_v = {rst_b, rst_a};
  assign fs_v  = {fsync_b, fsync_a};
  assign sdi_v = {sdi_b, sdi_a};

  for (genvar d = 0; d < NP; d++) begin : g_lane
    localparam int S = d;        // source port
    localparam int K = NP-1-d;   // sink port
    logic              done;
    logic [WORD_W-1:0] word;
    logic              rd_tog, rd_sel, guard, sdo_w;
    logic [WORD_W-1:0] rd_word;

    pcm_rx #(.WORD_W(WORD_W)) u_rx (
      .clk(clk_v[S]), .rst(rst_v[S]), .fsync(fs_v[S]), .sdi(sdi_v[S]),
      .done(done), .word(word));

    pcm_xfer #(.WORD_W(WORD_W)) u_xfer (
      .wclk(clk_v[S]), .wrst(rst_v[S]), .wr_done(done), .wr_word(word),
      .rclk(clk_v[K]), .rrst(rst_v[K]), .rd_guard(guard), .rd_sel(rd_sel),
      .rd_tog(rd_tog), .rd_word(rd_word));

    pcm_tx #(.WORD_W(WORD_W), .GUARD_LEN(GUARD_LEN)) u_tx (
      .clk(clk_v[K]), .rst(rst_v[K]), .fsync(fs_v[K]), .rd_tog(rd_tog),
      .rd_word(rd_word), .rd_sel(rd_sel), .guard(guard), .sdo(sdo_w));
  end

  assign sdo_b = g_lane[0].sdo_w;
  assign sdo_a = g_lane[1].sdo_w;

  // R10: a port held in reset drives a quiet output
  p_reset_quiet_r10: assert property (@(posedge clk_a)
    $past(rst_a) && rst_a |-> !sdo_a);
endmodule

// File: tb/sim_pcm_word_bridge.sv
`timescale 1ns/1ps
module sim_pcm_word_bridge;
  localparam int W     = 16;
  localparam int FRAME = 32;
  localparam int NFR   = 150;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a = 1'b1, rst_b = 1'b1;
  logic [1:0] fs = '0, sd = '0;
  logic sdo_a, sdo_b;
  bit   run = 1'b0, done_f = 1'b0;

  always #10   clk_a = ~clk_a;  // 50 MHz
  always #10.3 clk_b = ~clk_b;  // unrelated

  pcm_word_bridge u0 (
    .clk_a(clk_a), .rst_a(rst_a), .fsync_a(fs[0]), .sdi_a(sd[0]), .sdo_a(sdo_a),
    .clk_b(clk_b), .rst_b(rst_b), .fsync_b(fs[1]), .sdi_b(sd[1]), .sdo_b(sdo_b));

  int n_chk = 0, n_fail = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    done_f = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // source model: per port p
  int          fc [2] = '{0, 0};
  int          fr [2] = '{0, 0};
  logic [15:0] inw [2][256];
  realtime     tdn [2][256];
  int          nin [2] = '{0, 0};

  function automatic logic [15:0] word_of(int p, int n);
    return (p == 0) ? 16'(16'h1001 + n * 3) : 16'(16'h9002 + n * 5);
  endfunction

  task automatic src_step(int p);
    logic [15:0] w;
    if (fr[p] < NFR) begin
      w     = word_of(p, fr[p]);
      fs[p] = (fc[p] == 0);
      sd[p] = (fc[p] < W) ? w[W-1-fc[p]] : (fc[p][0] ^ fr[p][0]);  // R1 tail garbage
      if (fc[p] == W-1) begin
        inw[p][nin[p]] = w;
        tdn[p][nin[p]] = $realtime;
        nin[p]++;
      end
      fc[p]++;
      if (fc[p] == FRAME) begin
        fc[p] = 0;
        fr[p]++;
      end
    end else begin
      fs[p] = 1'b0;
      sd[p] = 1'b0;
    end
  endtask

  always @(negedge clk_a) if (run) src_step(0);
  always @(negedge clk_b) if (run) src_step(1);

  // sink model: direction d (0: A->B, 1: B->A)
  int          k    [2] = '{100, 100};
  bit          fpv  [2] = '{1'b0, 1'b0};
  logic [15:0] acc  [2];
  realtime     te0  [2];
  int          last [2] = '{-1, -1};
  int          rep  [2] = '{0, 0};
  int          drp  [2] = '{0, 0};
  int          nout [2] = '{0, 0};

  task automatic check_word(int d);
    int found;
    nout[d]++;
    if (last[d] < 0 && acc[d] == 16'h0) begin
      chk(1'b1, "R7", "idle zero word", acc[d], 0);
      return;
    end
    found = -1;
    for (int j = (last[d] < 0 ? 0 : last[d]); j < nin[d]; j++) begin
      if (inw[d][j] == acc[d] && tdn[d][j] < te0[d]) begin
        found = j;
        break;
      end
    end
    // R1 R2 R5 R6 R8: framing, handoff, guard, bit timing, integrity and order
    chk(found >= 0, "R8", "sent word not a finished input word", acc[d],
        (last[d] >= 0) ? int'(inw[d][last[d]]) : 0);
    if (found >= 0) begin
      if (found == last[d])                          rep[d]++;
      else if (last[d] >= 0 && found > last[d] + 1) drp[d]++;
      last[d] = found;
    end
  endtask

  task automatic sink_step(int d, logic f, logic so);
    if (f && !fpv[d]) begin
      k[d]   = 0;
      te0[d] = $realtime;
    end else if (k[d] < 100) begin
      k[d]++;
    end
    fpv[d] = f;
    if (k[d] >= 2 && k[d] <= W + 1) begin
      acc[d] = {acc[d][14:0], so};
      if (k[d] == W + 1) check_word(d);
    end else begin
      chk(so == 1'b0, "R7", "output outside word window", so, 0);
    end
  endtask

  always @(posedge clk_b) if (run && !done_f) sink_step(0, fs[1], sdo_b);
  always @(posedge clk_a) if (run && !done_f) sink_step(1, fs[0], sdo_a);

  initial begin
    repeat (4) @(posedge clk_a);
    #1;
    chk(sdo_a == 1'b0, "R10", "sdo_a during reset", sdo_a, 0);
    chk(sdo_b == 1'b0, "R10", "sdo_b during reset", sdo_b, 0);
    @(negedge clk_a) rst_a = 1'b0;
    @(negedge clk_b) rst_b = 1'b0;
    run = 1'b1;
    wait (fr[0] >= NFR && fr[1] >= NFR);
    repeat (3 * FRAME) @(posedge clk_a);
    #1;
    chk(nout[0] >= 100, "R9", "A->B words sent", nout[0], 100);
    chk(nout[1] >= 100, "R9", "B->A words sent", nout[1], 100);
    chk(drp[0] > 0, "R3", "A->B overtaken words dropped", drp[0], 1);
    chk(rep[1] > 0, "R4", "B->A words repeated", rep[1], 1);
    chk(last[0] >= NFR - 10, "R8", "A->B reached late words", last[0], NFR - 10);
    chk(last[1] >= NFR - 10, "R8", "B->A reached late words", last[1], NFR - 10);
    finish_up();
  end

  initial begin
    #500000;
    if (!done_f) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
      finish_up();
    end
  end
endmodule